// File: doc/BRIEF.md
# Multi-Context Folding Logic Element

This block is one programmable logic cell that can change its function while it runs. It holds a set of configuration words in a small local store. One of them, the active context, sits in a working register and drives a 4-input lookup table. The table feeds a D flip-flop. A sequencer moves the working register to the next stored word after a programmable number of evaluations. Over successive cycles the one cell can therefore compute a chain of different functions, a technique known as temporal folding.

Contexts are written through a simple write port while the cell is idle. The cell is then started by holding `run` high. Each cycle with `run` high counts as one evaluation. The folding level sets how many evaluations happen before the next context is loaded. The number of contexts in use sets where the index wraps back to zero. The flip-flop is never cleared by a context switch, so a result from one stage is still available in the next.

Top module: `fold_le`

## Requirements
- R1: After a synchronous reset the context index is 0, the flip-flop output is 0 and the wrap pulse is low.
- R2: `lut_y` equals bit `din` of the 16-bit truth table held in bits 15:0 of the active context word, with `din` used as an unsigned index.
- R3: On every rising edge with `run` high the flip-flop loads `lut_y`. With `run` low it keeps its value.
- R4: Output `le_out[i]` shows the flip-flop when bit 16+i of the active word is 1, and shows `lut_y` when that bit is 0.
- R5: With `run` high the active context advances after every `fold_lvl` evaluations. A `fold_lvl` of 1 or 0 switches on every evaluation.
- R6: The index counts modulo `ctx_count` (1 to 16) and returns to 0 after context `ctx_count`-1. With `ctx_count` = 1 it stays at 0.
- R7: `ctx_wrap` is high for the one cycle after each edge where the index returned to 0, and in that cycle the index reads 0.
- R8: A context switch leaves the flip-flop unchanged, so the value from the previous context is visible through an output whose select bit is 1 in the new context.
- R9: A context write presented while `run` is high is ignored, and the stored word keeps its old value.
- R10: While `run` is low the context index, the evaluation count and the flip-flop hold. A write is accepted, and a write to the active context shows at the outputs on the second rising edge after the write is presented. After `run` returns high, the evaluation count continues from where it stopped.
- R11: Bits 47:18 of a context word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Evaluate and sequence when high, hold when low |
| fold_lvl | input | 4 | Evaluations per context (0 treated as 1) |
| ctx_count | input | 5 | Number of contexts in the rotation, 1 to 16 |
| cfg_we | input | 1 | Context write strobe |
| cfg_addr | input | 4 | Context slot to write |
| cfg_wdata | input | 48 | Context word to write |
| din | input | 4 | Lookup table inputs |
| lut_y | output | 1 | Combinational lookup table result |
| ff_q | output | 1 | Flip-flop output |
| le_out | output | 2 | Per-output choice of registered or combinational result |
| ctx_idx | output | 4 | Index of the active context |
| ctx_wrap | output | 1 | One-cycle pulse after the index wraps to 0 |

## Verification
Every context is loaded with a one-hot truth table, so the flip-flop value after each evaluation shows which context was active at that edge. A wrong index, an off-by-one in the switch or a stale working register all show up as a misplaced 1. Three runs use a fixed `din` with different settings. A four-context run at level 1 is stopped mid-rotation to expose how the flip-flop carries its value across a switch. A three-context run at level 3 is paused mid-interval, which separates a count that resumes from one that restarts. A sixteen-context run with a level of 0 covers the full wrap. A final pattern with a denser truth table, reserved bits all set and a write made while running tells apart index decoding, reserved-bit leakage and writes that should have been blocked.

// File: rtl/fold_le_pkg.sv
package fold_le_pkg;

  // Number of outputs per element, each with its own register/bypass select bit.
  localparam int LE_OUTS = 2;

  // Truth-table width for a k-input lookup table.
  function automatic int tt_width(input int k);
    return 1 << k;
  endfunction

  // Context bits that carry behaviour: truth table followed by output selects.
  function automatic int used_width(input int k);
    return (1 << k) + LE_OUTS;
  endfunction

endpackage

// File: rtl/fold_ctx_store.sv
// Context store: one write port, one registered read port (block RAM shape).
module fold_ctx_store #(
  parameter int DEPTH = 16,
  parameter int W     = 18,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Working configuration register, reloaded every cycle from the selected slot.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/fold_seq.sv
// Context sequencer: counts evaluations and steps the context index.
module fold_seq #(
  parameter int NUM_CTX = 16,
  parameter int PW      = 4,
  localparam int IDX_W  = $clog2(NUM_CTX),
  localparam int CNT_W  = $clog2(NUM_CTX + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PW-1:0]    fold_lvl,
  input  logic [CNT_W-1:0] ctx_count,
  output logic [IDX_W-1:0] ctx_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             ctx_wrap
);

  logic [PW-1:0]    eval_cnt;
  logic [PW-1:0]    lvl_eff;
  logic [CNT_W-1:0] n_eff;
  logic             last_eval;
  logic             last_ctx;
  logic             step;
  logic [IDX_W-1:0] nxt_idx;

  always_comb begin
    lvl_eff = (fold_lvl == '0) ? PW'(1) : fold_lvl;
    if (ctx_count == '0)                   n_eff = CNT_W'(1);
    else if (ctx_count > CNT_W'(NUM_CTX))  n_eff = CNT_W'(NUM_CTX);
    else                                   n_eff = ctx_count;
  end

  assign last_eval = (eval_cnt >= lvl_eff - PW'(1));
  assign last_ctx  = (CNT_W'(ctx_idx) >= n_eff - CNT_W'(1));
  assign step      = run & last_eval;
  assign nxt_idx   = last_ctx ? '0 : ctx_idx + IDX_W'(1);
  assign rd_idx    = step ? nxt_idx : ctx_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_idx  <= '0;
      eval_cnt <= '0;
      ctx_wrap <= 1'b0;
    end else begin
      ctx_wrap <= step & last_ctx;
      if (run) begin
        if (last_eval) begin
          eval_cnt <= '0;
          ctx_idx  <= nxt_idx;
        end else begin
          eval_cnt <= eval_cnt + PW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fold_lut_ff.sv
// Lookup table, state flip-flop and per-output bypass selection.
module fold_lut_ff #(
  parameter int LUT_K = 4,
  parameter int NOUT  = 2,
  localparam int TT_W = 1 << LUT_K
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [LUT_K-1:0] din,
  input  logic [TT_W-1:0]  tt,
  input  logic [NOUT-1:0]  osel,
  output logic             lut_y,
  output logic             ff_q,
  output logic [NOUT-1:0]  le_out
);

  assign lut_y = tt[din];

  // Not touched by a context switch: carries a value between folding stages.
  always_ff @(posedge clk) begin
    if (rst)      ff_q <= 1'b0;
    else if (run) ff_q <= lut_y;
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    assign le_out[g] = osel[g] ? ff_q : lut_y;
  end

endmodule

// File: rtl/fold_le.sv
module fold_le
  import fold_le_pkg::*;
#(
  parameter int NUM_CTX = 16,
  parameter int CFG_W   = 48,
  parameter int LUT_K   = 4,
  parameter int PW      = 4,
  localparam int IDX_W  = $clog2(NUM_CTX),
  localparam int CNT_W  = $clog2(NUM_CTX + 1)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PW-1:0]      fold_lvl,
  input  logic [CNT_W-1:0]   ctx_count,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [LUT_K-1:0]   din,
  output logic               lut_y,
  output logic               ff_q,
  output logic [LE_OUTS-1:0] le_out,
  output logic [IDX_W-1:0]   ctx_idx,
  output logic               ctx_wrap
);

  localparam int TT_W   = tt_width(LUT_K);
  localparam int USED_W = used_width(LUT_K);

  logic [IDX_W-1:0]  rd_idx;
  logic [USED_W-1:0] act_cfg;
  logic              store_we;

  // Writes are blocked while the sequencer runs.
  assign store_we = cfg_we & ~run;

  // Reserved crossbar-select bits are not stored.
  if (CFG_W > USED_W) begin : g_rsv
    logic unused_rsv;
    assign unused_rsv = ^cfg_wdata[CFG_W-1:USED_W];
  end

  fold_seq #(
    .NUM_CTX (NUM_CTX),
    .PW      (PW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .fold_lvl  (fold_lvl),
    .ctx_count (ctx_count),
    .ctx_idx   (ctx_idx),
    .rd_idx    (rd_idx),
    .ctx_wrap  (ctx_wrap)
  );

  fold_ctx_store #(
    .DEPTH (NUM_CTX),
    .W     (USED_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (store_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata[USED_W-1:0]),
    .raddr (rd_idx),
    .rdata (act_cfg)
  );

  fold_lut_ff #(
    .LUT_K (LUT_K),
    .NOUT  (LE_OUTS)
  ) u_lut (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .din    (din),
    .tt     (act_cfg[TT_W-1:0]),
    .osel   (act_cfg[USED_W-1:TT_W]),
    .lut_y  (lut_y),
    .ff_q   (ff_q),
    .le_out (le_out)
  );

endmodule

// File: rtl/fold_le_chk.sv
module fold_le_chk #(
  parameter int IDX_W = 4
)(
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             lut_y,
  input logic             ff_q,
  input logic [IDX_W-1:0] ctx_idx,
  input logic             ctx_wrap
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctx_idx == '0) && !ff_q && !ctx_wrap);

  // R3
  ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (ff_q == $past(lut_y)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(rst)) |=> ($stable(ctx_idx) && $stable(ff_q)));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_wrap |-> (ctx_idx == '0));

  // R5
  step_when_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(ctx_idx)) |-> $past(run));

endmodule

bind fold_le fold_le_chk #(.IDX_W(IDX_W)) u_fold_le_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .lut_y    (lut_y),
  .ff_q     (ff_q),
  .ctx_idx  (ctx_idx),
  .ctx_wrap (ctx_wrap)
);

// File: tb/fold_le_test.sv
module fold_le_test;

  localparam int CLK_P = 10;
  localparam int WD    = 5000;

  typedef struct {
    string       tag;
    int          sig;   // 0 lut_y, 1 ff_q, 2 le_out, 3 ctx_idx, 4 ctx_wrap
    int unsigned expv;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [3:0]  fold_lvl = 4'd1;
  logic [4:0]  ctx_count = 5'd1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [47:0] cfg_wdata = '0;
  logic [3:0]  din = '0;
  logic        lut_y, ff_q, ctx_wrap;
  logic [1:0]  le_out;
  logic [3:0]  ctx_idx;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fold_le uut (
    .clk(clk), .rst(rst), .run(run), .fold_lvl(fold_lvl), .ctx_count(ctx_count),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .din(din),
    .lut_y(lut_y), .ff_q(ff_q), .le_out(le_out), .ctx_idx(ctx_idx), .ctx_wrap(ctx_wrap)
  );

  // Monitor: after each rising edge, compare everything queued for that edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      while (sbq.size() > 0) begin
        item_t it;
        int unsigned av;
        it = sbq.pop_front();
        case (it.sig)
          0: av = lut_y;
          1: av = ff_q;
          2: av = le_out;
          3: av = ctx_idx;
          default: av = ctx_wrap;
        endcase
        n_chk++;
        if (av !== it.expv) begin
          n_err++;
          $display("FAIL %s: actual %0d expected %0d", it.tag, av, it.expv);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic want(input string tag, input int sig, input int unsigned v);
    item_t it;
    it.tag = tag; it.sig = sig; it.expv = v;
    sbq.push_back(it);
  endtask

  task automatic wr(input int a, input logic [47:0] w);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    run = 1'b0; rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  // One-hot table: context c outputs 1 only for din == c; output 0 registered.
  function automatic logic [47:0] mkw(input int c);
    return {30'(c * 37 + 5), 1'b0, 1'b1, 16'(1 << c)};
  endfunction

  initial begin
    tick();
    do_reset();
    // R1: reset state
    want("R1 idx", 3, 0); want("R1 ff", 1, 0); want("R1 wrap", 4, 0);
    tick();

    for (int c = 0; c < 16; c++) wr(c, mkw(c));
    tick(); tick();

    // R2 / R4 / R11: context 0 table 0x0001, reserved bits nonzero
    din = 4'd0;
    want("R2 lut din0", 0, 1); want("R4 le_out", 2, 2'b10);
    tick();
    din = 4'd1;
    want("R2 lut din1", 0, 0); want("R4 le_out", 2, 2'b00);
    tick();

    // Run A: four contexts, level 1, din = 2
    run = 1'b1; ctx_count = 5'd4; fold_lvl = 4'd1; din = 4'd2;
    for (int i = 0; i < 7; i++) begin
      want("R5 idx A", 3, (i + 1) % 4);
      want("R3 ff A", 1, int'(i % 4 == 2));
      want("R7 wrap A", 4, int'((i + 1) % 4 == 0));
      tick();
    end
    run = 1'b0;
    for (int j = 0; j < 2; j++) begin
      want("R10 idx hold", 3, 3); want("R3 ff hold", 1, 1);
      tick();
    end
    // R8: ff from context 2 seen through context 3's registered output
    want("R8 le_out", 2, 2'b01);
    tick();

    // Run B: three contexts, level 3, din = 1, paused mid-interval
    do_reset();
    run = 1'b1; ctx_count = 5'd3; fold_lvl = 4'd3; din = 4'd1;
    for (int k = 0; k < 10; k++) begin
      if (k == 5) begin
        run = 1'b0;
        for (int j = 0; j < 2; j++) begin
          want("R10 pause idx", 3, 1); want("R10 pause ff", 1, 1);
          want("R10 pause wrap", 4, 0);
          tick();
        end
        run = 1'b1;
      end
      want("R5 idx B", 3, ((k + 1) / 3) % 3);
      want("R6 ff B", 1, int'(((k / 3) % 3) == 1));
      want("R7 wrap B", 4, int'((k + 1) % 9 == 0));
      tick();
    end
    run = 1'b0;
    tick();

    // Run C: sixteen contexts, level 0 (acts as 1), din = 5
    do_reset();
    run = 1'b1; ctx_count = 5'd16; fold_lvl = 4'd0; din = 4'd5;
    for (int k = 0; k < 18; k++) begin
      want("R6 idx C", 3, (k + 1) % 16);
      want("R5 ff C", 1, int'(k % 16 == 5));
      want("R7 wrap C", 4, int'((k + 1) % 16 == 0));
      tick();
    end
    run = 1'b0;
    tick();

    // R10 / R11: idle write to active context, reserved bits all ones
    do_reset();
    wr(0, {30'h3FFF_FFFF, 1'b1, 1'b0, 16'h0F0F});
    din = 4'd3;
    want("R10 idle write lut", 0, 1); want("R11 le_out", 2, 2'b01);
    tick();
    din = 4'd4;
    want("R2 lut din4", 0, 0); want("R11 le_out", 2, 2'b00);
    tick();
    din = 4'd8;
    want("R2 lut din8", 0, 1);
    tick();

    // R9: single context, write attempted while running
    din = 4'd3; run = 1'b1; ctx_count = 5'd1; fold_lvl = 4'd1;
    want("R6 single idx", 3, 0); want("R3 ff", 1, 1); want("R7 wrap single", 4, 1);
    tick();
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = '0;
    want("R6 single idx", 3, 0); want("R9 ff", 1, 1);
    tick();
    cfg_we = 1'b0; run = 1'b0;
    want("R9 lut kept", 0, 1);
    tick();
    want("R9 lut kept", 0, 1); want("R7 wrap low", 4, 0);
    tick();
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", WD, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule